// File: doc/BRIEF.md
# Software Watchdog Counter with Coherent Byte Readback

This block is a memory-mapped software watchdog. It holds a control word with a 15-bit limit field and an enable bit, and a 16-bit up-counter that advances once per period of a power-of-two clock prescaler. When the counter's upper fifteen bits equal the limit field, the block raises a one-cycle `timeout_o` pulse and the count starts again from zero. Software keeps the system alive by writing the counter often enough that the limit is never reached. Any write to the counter restarts both the counter and the prescaler, whatever data is written and whichever byte is addressed.

The counter can be read at any time over a 16-bit or an 8-bit data path, chosen by `wide_bus_i`. On the 8-bit path a read of the counter's high byte also copies the live low byte into a holding register. A later low-byte read returns that copy, so the two bytes always come from the same count value. Reads never affect counting.

A small state machine sets when the pulse fires. Its states are OFF (disabled, counter and prescaler held at zero), RUN (counting) and FIRE (the one-cycle pulse). The transitions are OFF to RUN when the enable bit is set; RUN to FIRE on a limit match with no counter write in the same cycle; FIRE to RUN after one cycle; and RUN or FIRE to OFF whenever the enable bit is cleared. Reset enters RUN.

Top module: `wdt_core`

## Requirements
- R1: After reset the control word reads 16'hFFFF (limit field all ones, enable bit set), the counter reads 0 and `timeout_o` is low.
- R2: While enabled, the counter rises by one every 2^PRESC_LOG2 clock cycles, counted from the last restart.
- R3: A control-word write with bit 0 clear holds the counter at zero and keeps `timeout_o` low until the bit is set again.
- R4: With the enable bit set, once counter bits 15..1 equal control bits 15..1, `timeout_o` is high for exactly one cycle, in the cycle after the match, and the counter restarts from zero. After a restart and a limit value L, the pulse is seen 2*L*2^PRESC_LOG2+1 clock edges after the restart edge and then once every 2*L*2^PRESC_LOG2+1 edges.
- R5: With `wide_bus_i`=1, a read at `addr_i`[1]=1 returns the live 16-bit count and a read at `addr_i`[1]=0 returns the full control word.
- R6: With `wide_bus_i`=0, a read at `addr_i`=2'b10 returns count bits 15..8 on `rdata_o`[7:0] and captures count bits 7..0 into the holding register.
- R7: With `wide_bus_i`=0, a read at `addr_i`=2'b11 returns the holding register, not the live low byte, and the holding register changes only on a high-byte read.
- R8: Counter reads of any kind do not change the count sequence.
- R9: Any write with `addr_i`[1]=1 clears the counter and the prescaler. This covers a 16-bit write and an 8-bit write to either 2'b10 or 2'b11.
- R10: With `wide_bus_i`=0, control-word writes at 2'b00 load bits 15..8 and writes at 2'b01 load bits 7..0 from `wdata_i`[7:0]. Byte reads return the matching byte with `rdata_o`[15:8]=0. With `wide_bus_i`=1, a write at `addr_i`[1]=0 loads all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_bus_i | input | 1 | 1 selects 16-bit access, 0 selects 8-bit access |
| sel_i | input | 1 | Bus access valid this cycle |
| wr_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 2 | Bit 1 picks the register (0 control, 1 counter); bit 0 picks the byte in 8-bit mode (0 high, 1 low) |
| wdata_i | input | 16 | Write data; only bits 7..0 are used in 8-bit mode |
| rdata_o | output | 16 | Read data during a read access, zero otherwise |
| timeout_o | output | 1 | One-cycle pulse on a limit match |

## Verification
The bench builds the block with PRESC_LOG2=2, so the counter steps every four cycles. This puts the count carry from 255 to 256 within about a thousand cycles, which lets the bench check that a high-byte capture stays coherent across a byte carry. It also means a small limit value gives a timeout after a few dozen edges. That exposes the exact pulse latency, the single-cycle width and the period between pulses. The reset value of the limit cannot be reached at this divide ratio, so only the reset contents of the control word are checked.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int LIM_W  = CNT_W - 1;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdt_state_e;

    localparam logic [CNT_W-1:0] CTRL_RESET = {CNT_W{1'b1}};
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRESC_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    output logic tick_o
);
    generate
        if (PRESC_LOG2 == 0) begin : g_bypass
            assign tick_o = en_i;
        end else begin : g_div
            logic [PRESC_LOG2-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (!en_i || clr_i) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick_o = en_i && (div_q == {PRESC_LOG2{1'b1}});

            AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> (div_q == '0)); // R2
        end
    endgenerate
endmodule

// File: rtl/wdt_count_fsm.sv
module wdt_count_fsm
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [LIM_W-1:0] limit_i,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             timeout_o
);
    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             match;

    assign match = (cnt_q[CNT_W-1:1] == limit_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = en_i ? ST_RUN : ST_OFF;
            ST_RUN: begin
                if (!en_i)                state_d = ST_OFF;
                else if (match && !clr_i) state_d = ST_FIRE;
                else                      state_d = ST_RUN;
            end
            ST_FIRE: state_d = en_i ? ST_RUN : ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        wrap_o    = (state_q == ST_RUN) && en_i && !clr_i && match;
        timeout_o = (state_q == ST_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || clr_i || wrap_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    assign cnt_o = cnt_q;

    AST_OFF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0)); // R3
    AST_TIMEOUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0)); // R4
    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R9
    AST_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 16'd1) || (cnt_q == '0))); // R2
endmodule

// File: rtl/wdt_byte_hold.sv
module wdt_byte_hold
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [BYTE_W-1:0] lo_i,
    output logic [BYTE_W-1:0] hold_o
);
    logic [BYTE_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hold_q <= '0;
        else if (cap_i) hold_q <= lo_i;
    end

    assign hold_o = hold_q;

    AST_HOLD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (hold_q == $past(lo_i))); // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(hold_q)); // R7
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int PRESC_LOG2 = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wide_bus_i,
    input  logic        sel_i,
    input  logic        wr_i,
    input  logic [1:0]  addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        timeout_o
);
    logic             rd_acc, wr_acc, is_cnt, byte_lo;
    logic             cnt_wr, cap, tick, wrap;
    logic [CNT_W-1:0] ctrl_q, cnt;
    logic [BYTE_W-1:0] hold;

    assign rd_acc  = sel_i && !wr_i;
    assign wr_acc  = sel_i && wr_i;
    assign is_cnt  = addr_i[1];
    assign byte_lo = addr_i[0];
    assign cnt_wr  = wr_acc && is_cnt;
    assign cap     = rd_acc && is_cnt && !wide_bus_i && !byte_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_acc && !is_cnt) begin
            if (wide_bus_i)   ctrl_q                     <= wdata_i;
            else if (byte_lo) ctrl_q[BYTE_W-1:0]         <= wdata_i[BYTE_W-1:0];
            else              ctrl_q[CNT_W-1:BYTE_W]     <= wdata_i[BYTE_W-1:0];
        end
    end

    wdt_prescaler #(.PRESC_LOG2(PRESC_LOG2)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctrl_q[0]),
        .clr_i  (cnt_wr || wrap),
        .tick_o (tick)
    );

    wdt_count_fsm u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (ctrl_q[0]),
        .limit_i   (ctrl_q[CNT_W-1:1]),
        .clr_i     (cnt_wr),
        .tick_i    (tick),
        .cnt_o     (cnt),
        .wrap_o    (wrap),
        .timeout_o (timeout_o)
    );

    wdt_byte_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .lo_i   (cnt[BYTE_W-1:0]),
        .hold_o (hold)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_acc) begin
            if (wide_bus_i) begin
                rdata_o = is_cnt ? cnt : ctrl_q;
            end else if (is_cnt) begin
                rdata_o[BYTE_W-1:0] = byte_lo ? hold : cnt[CNT_W-1:BYTE_W];
            end else begin
                rdata_o[BYTE_W-1:0] = byte_lo ? ctrl_q[BYTE_W-1:0] : ctrl_q[CNT_W-1:BYTE_W];
            end
        end
    end

    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && !is_cnt) |=> $stable(ctrl_q)); // R10
    AST_READ_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && ctrl_q[0] && !wrap && cnt != 16'hFFFF) |=> (cnt != '0 || $past(cnt) == '0)); // R8
endmodule

// File: tb/wdt_core_tb_top.sv
module wdt_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_bus_i = 1'b1;
    logic        sel_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [1:0]  addr_i = 2'b00;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        timeout_o;

    int total = 0;
    int bad = 0;
    int edge_n = 0;
    int e0 = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    wdt_core #(.PRESC_LOG2(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wide_bus_i(wide_bus_i), .sel_i(sel_i),
        .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .timeout_o(timeout_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        sel_i = 1'b0; wr_i = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
        #1 d = rdata_o;
        @(negedge clk);
        sel_i = 1'b0;
    endtask

    task automatic restart(input logic [1:0] a);
        bus_write(a, 16'h0000);
        e0 = edge_n;
    endtask

    task automatic wait_k(input int k);
        while (edge_n < e0 + k) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        sel_i = 1'b1; wr_i = 1'b0; addr_i = 2'b00;
        #1 v = rdata_o;
        chk("R1 control word after reset", v, 16'hFFFF);
        addr_i = 2'b10;
        #1 v = rdata_o;
        chk("R1 counter after reset", v, 0);
        chk("R1 timeout after reset", timeout_o, 0);
        sel_i = 1'b0;
    endtask

    task automatic t_rate;
        logic [15:0] v;
        wide_bus_i = 1'b1;
        restart(2'b10);
        wait_k(10);
        bus_read(2'b10, v);
        chk("R2 R5 count at 10 edges", v, 2);
        wait_k(33);
        bus_read(2'b10, v);
        chk("R2 R5 count at 33 edges", v, 8);
        bus_read(2'b00, v);
        chk("R5 control word read", v, 16'hFFFF);
    endtask

    task automatic t_timeout;
        logic [15:0] v;
        wide_bus_i = 1'b1;
        bus_write(2'b00, 16'h0007);
        restart(2'b10);
        while (!timeout_o && edge_n - e0 < 200) @(negedge clk);
        chk("R4 first pulse edge", edge_n - e0, 25);
        @(negedge clk);
        chk("R4 pulse width one cycle", timeout_o, 0);
        bus_read(2'b10, v);
        chk("R4 counter restarted", v, 0);
        while (!timeout_o && edge_n - e0 < 200) @(negedge clk);
        chk("R4 second pulse edge", edge_n - e0, 50);
        bus_write(2'b00, 16'hFFFF);
    endtask

    task automatic t_disable;
        logic [15:0] v;
        int seen = 0;
        wide_bus_i = 1'b1;
        bus_write(2'b00, 16'h0006);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (timeout_o) seen++;
        end
        chk("R3 no pulse while disabled", seen, 0);
        bus_read(2'b10, v);
        chk("R3 counter held at zero", v, 0);
        bus_write(2'b00, 16'hFFFF);
    endtask

    task automatic t_byte_latch;
        logic [15:0] v;
        wide_bus_i = 1'b0;
        restart(2'b10);
        wait_k(10);
        bus_read(2'b10, v);
        chk("R6 high byte at count 2", v, 0);
        wait_k(30);
        bus_read(2'b11, v);
        chk("R7 low byte is captured copy", v, 2);
        wide_bus_i = 1'b1;
        bus_read(2'b10, v);
        chk("R7 live count differs", v, 7);
        wait_k(40);
        bus_read(2'b10, v);
        chk("R8 reads left count intact", v, 10);
    endtask

    task automatic t_carry;
        logic [15:0] v;
        wide_bus_i = 1'b0;
        restart(2'b11);
        wait_k(1021);
        bus_read(2'b10, v);
        chk("R6 high byte before carry", v, 16'h00);
        wait_k(1030);
        bus_read(2'b11, v);
        chk("R7 low byte coherent across carry", v, 16'hFF);
        bus_read(2'b10, v);
        chk("R6 high byte after carry", v, 16'h01);
        bus_read(2'b11, v);
        chk("R6 R7 new capture", v, 16'h01);
    endtask

    task automatic t_write_restart;
        logic [15:0] v;
        wide_bus_i = 1'b1;
        restart(2'b10);
        wait_k(40);
        restart(2'b10);
        wait_k(5);
        bus_read(2'b10, v);
        chk("R9 16-bit write restarts", v, 1);
        wait_k(40);
        wide_bus_i = 1'b0;
        restart(2'b10);
        wide_bus_i = 1'b1;
        wait_k(5);
        bus_read(2'b10, v);
        chk("R9 high byte write restarts", v, 1);
        wait_k(40);
        wide_bus_i = 1'b0;
        restart(2'b11);
        wide_bus_i = 1'b1;
        wait_k(9);
        bus_read(2'b10, v);
        chk("R9 low byte write restarts", v, 2);
    endtask

    task automatic t_ctrl_bytes;
        logic [15:0] v;
        wide_bus_i = 1'b0;
        bus_write(2'b00, 16'hAB12);
        bus_write(2'b01, 16'hCD35);
        bus_read(2'b00, v);
        chk("R10 control high byte", v, 16'h0012);
        bus_read(2'b01, v);
        chk("R10 control low byte upper zero", v, 16'h0035);
        wide_bus_i = 1'b1;
        bus_read(2'b00, v);
        chk("R10 control full word", v, 16'h1235);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_rate();
        t_timeout();
        t_disable();
        t_byte_latch();
        t_carry();
        t_write_restart();
        t_ctrl_bytes();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule